// File: doc/BRIEF.md
# Packet Control-Bus Tree Switch

This block is one node of a tree-shaped, full-duplex control network with a single root. Every link carries 16-bit words framed by start and end markers. A word moves only in a cycle where the sender's valid flag and the receiver's ready flag are both high. One side of the node faces the root. The other side fans out to a parameterised number of leaf links, each leading to an endpoint or to a deeper switch.

Traffic from the root goes down and is copied to every leaf link, with no address decoding. Traffic from the leaves goes up: a round-robin arbiter admits one leaf packet at a time and sends it toward the root. Leaf traffic is never turned back down, so endpoints cannot talk to each other through the switch. Each direction has one register stage, so a chain of switches also serves as a pipeline that breaks long wires across the die.

Top module: `cbsw_switch`

## Requirements
- R1: While reset is high, and after reset until new input arrives, every output valid flag (`rt_up_src_rdy` and all bits of `lf_dn_src_rdy`) is low.
- R2: Every word accepted from the root link appears on every leaf link unchanged in data, start marker and end marker, in acceptance order, exactly once per leaf.
- R3: A leaf output valid flag is high only in a cycle where every leaf ready flag is high. All leaf valid flags are then high together, so each word is taken by all leaves in the same cycle.
- R4: While the root does not accept an upward word, that word stays on `rt_up_*` unchanged and valid. No further leaf word is accepted while the stage holds a word that cannot move.
- R5: Words accepted from leaves reach only the root output, in the order they were accepted. They never appear on any leaf output.
- R6: When no packet is in progress upward, the leaf that wins is the first one presenting a start word (valid and start marker both high) in ascending index order. The search starts just after the last winner, wraps from the top index to 0, and starts at leaf 0 after reset.
- R7: Once a leaf's start word is accepted without an end marker, only that leaf is accepted until its end-marked word has been transferred.
- R8: At most one bit of `lf_up_dst_rdy` is high in any cycle, and only the granted leaf sees ready.
- R9: A single-word packet (start and end marker in the same word) releases the grant in the cycle it is transferred. Another waiting leaf is accepted in the very next cycle.
- R10: Each direction has one register stage. A word accepted at a clock edge is presented on the far side right after that same edge, provided the stage was free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rt_dn_data | input | 16 | Downward word from the root side |
| rt_dn_sop | input | 1 | Start marker of downward word |
| rt_dn_eop | input | 1 | End marker of downward word |
| rt_dn_src_rdy | input | 1 | Root side offers a downward word |
| rt_dn_dst_rdy | output | 1 | Switch can take a downward word |
| rt_up_data | output | 16 | Upward word toward the root |
| rt_up_sop | output | 1 | Start marker of upward word |
| rt_up_eop | output | 1 | End marker of upward word |
| rt_up_src_rdy | output | 1 | Switch offers an upward word |
| rt_up_dst_rdy | input | 1 | Root side takes the upward word |
| lf_dn_data | output | 16*N_LEAF | Broadcast word, one copy per leaf |
| lf_dn_sop | output | N_LEAF | Start marker per leaf |
| lf_dn_eop | output | N_LEAF | End marker per leaf |
| lf_dn_src_rdy | output | N_LEAF | Word offered to each leaf |
| lf_dn_dst_rdy | input | N_LEAF | Each leaf can take a word |
| lf_up_data | input | 16*N_LEAF | Upward word from each leaf |
| lf_up_sop | input | N_LEAF | Start marker per leaf |
| lf_up_eop | input | N_LEAF | End marker per leaf |
| lf_up_src_rdy | input | N_LEAF | Each leaf offers a word |
| lf_up_dst_rdy | output | N_LEAF | Ready returned to each leaf |

## Verification
The hardest case to reach from the ports is a grant handover with no idle cycle: a single-word packet from one leaf followed straight away by a start word from another waiting leaf, with the upward stage free. A directed sequence stalls the stage, lines up two single-word packets on adjacent leaves, then opens the root side. It checks that one leaf is taken and the other in the next cycle. Long random runs with random ready patterns on every link then cover interleaving attempts, wrap-around of the round-robin order and partial downward backpressure. A model of the fairness order predicts each winner.

// File: rtl/cbsw_pkg.sv
package cbsw_pkg;

    localparam int WORD_W = 16;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              sop;
        logic              eop;
    } cb_word_t;

    typedef enum logic {
        ARB_OPEN   = 1'b0,
        ARB_LOCKED = 1'b1
    } arb_state_e;

    function automatic cb_word_t make_word(input logic [WORD_W-1:0] d,
                                           input logic s, input logic e);
        cb_word_t w;
        w.data = d;
        w.sop  = s;
        w.eop  = e;
        return w;
    endfunction

endpackage

// File: rtl/cbsw_stage.sv
module cbsw_stage
    import cbsw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cb_word_t in_word,
    input  logic     in_vld,
    output logic     in_rdy,
    output cb_word_t out_word,
    output logic     out_vld,
    input  logic     out_rdy
);

    cb_word_t hold_q;
    logic     vld_q;

    assign in_rdy   = !vld_q || out_rdy;
    assign out_word = hold_q;
    assign out_vld  = vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            hold_q <= '0;
        end else if (in_rdy) begin
            vld_q <= in_vld;
            if (in_vld) begin
                hold_q <= in_word;
            end
        end
    end

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_vld && !out_rdy) |=> (out_vld && $stable(out_word)));

endmodule

// File: rtl/cbsw_rr_arb.sv
module cbsw_rr_arb
    import cbsw_pkg::*;
#(
    parameter int N_LEAF = 4,
    localparam int IDX_W = (N_LEAF > 1) ? $clog2(N_LEAF) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_LEAF-1:0] start_req,
    input  logic              xfer,
    input  logic              xfer_eop,
    output logic              gnt_vld,
    output logic [IDX_W-1:0]  gnt_idx
);

    arb_state_e       state_q;
    logic [IDX_W-1:0] owner_q;
    logic [IDX_W-1:0] last_q;
    logic [IDX_W-1:0] pick;
    logic             found;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = 1; k <= N_LEAF; k++) begin
            int idx;
            idx = (int'(last_q) + k) % N_LEAF;
            if (!found && start_req[idx]) begin
                found = 1'b1;
                pick  = idx[IDX_W-1:0];
            end
        end
    end

    assign gnt_vld = (state_q == ARB_LOCKED) || found;
    assign gnt_idx = (state_q == ARB_LOCKED) ? owner_q : pick;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARB_OPEN;
            owner_q <= '0;
            last_q  <= IDX_W'(N_LEAF - 1);
        end else if (xfer) begin
            last_q <= gnt_idx;
            if (xfer_eop) begin
                state_q <= ARB_OPEN;
            end else begin
                state_q <= ARB_LOCKED;
                owner_q <= gnt_idx;
            end
        end
    end

    // R7
    grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ARB_LOCKED && !(xfer && xfer_eop))
        |=> (state_q == ARB_LOCKED && $stable(owner_q)));

    // R9
    single_release_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer && xfer_eop) |=> (state_q == ARB_OPEN));

endmodule

// File: rtl/cbsw_bcast.sv
module cbsw_bcast
    import cbsw_pkg::*;
#(
    parameter int N_LEAF = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_vld,
    output logic              word_take,
    input  logic [N_LEAF-1:0] leaf_rdy,
    output logic [N_LEAF-1:0] leaf_vld
);

    logic all_rdy;

    assign all_rdy   = &leaf_rdy;
    assign word_take = all_rdy;

    for (genvar g = 0; g < N_LEAF; g++) begin : g_fan
        assign leaf_vld[g] = word_vld && all_rdy;
    end

    // R3
    bcast_together_chk: assert property (@(posedge clk) disable iff (rst)
        (|leaf_vld) |-> ((&leaf_rdy) && (&leaf_vld)));

endmodule

// File: rtl/cbsw_switch.sv
module cbsw_switch
    import cbsw_pkg::*;
#(
    parameter int N_LEAF = 4,
    localparam int IDX_W = (N_LEAF > 1) ? $clog2(N_LEAF) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [WORD_W-1:0]        rt_dn_data,
    input  logic                     rt_dn_sop,
    input  logic                     rt_dn_eop,
    input  logic                     rt_dn_src_rdy,
    output logic                     rt_dn_dst_rdy,
    output logic [WORD_W-1:0]        rt_up_data,
    output logic                     rt_up_sop,
    output logic                     rt_up_eop,
    output logic                     rt_up_src_rdy,
    input  logic                     rt_up_dst_rdy,
    output logic [N_LEAF*WORD_W-1:0] lf_dn_data,
    output logic [N_LEAF-1:0]        lf_dn_sop,
    output logic [N_LEAF-1:0]        lf_dn_eop,
    output logic [N_LEAF-1:0]        lf_dn_src_rdy,
    input  logic [N_LEAF-1:0]        lf_dn_dst_rdy,
    input  logic [N_LEAF*WORD_W-1:0] lf_up_data,
    input  logic [N_LEAF-1:0]        lf_up_sop,
    input  logic [N_LEAF-1:0]        lf_up_eop,
    input  logic [N_LEAF-1:0]        lf_up_src_rdy,
    output logic [N_LEAF-1:0]        lf_up_dst_rdy
);

    // ---------------- downward: register then broadcast ----------------
    cb_word_t dn_in_w, dn_out_w;
    logic     dn_out_vld, dn_take;

    assign dn_in_w = make_word(rt_dn_data, rt_dn_sop, rt_dn_eop);

    cbsw_stage u_dn_stage (
        .clk      (clk),
        .rst      (rst),
        .in_word  (dn_in_w),
        .in_vld   (rt_dn_src_rdy),
        .in_rdy   (rt_dn_dst_rdy),
        .out_word (dn_out_w),
        .out_vld  (dn_out_vld),
        .out_rdy  (dn_take)
    );

    cbsw_bcast #(.N_LEAF(N_LEAF)) u_bcast (
        .clk       (clk),
        .rst       (rst),
        .word_vld  (dn_out_vld),
        .word_take (dn_take),
        .leaf_rdy  (lf_dn_dst_rdy),
        .leaf_vld  (lf_dn_src_rdy)
    );

    for (genvar g = 0; g < N_LEAF; g++) begin : g_dn_copy
        assign lf_dn_data[g*WORD_W +: WORD_W] = dn_out_w.data;
        assign lf_dn_sop[g]                   = dn_out_w.sop;
        assign lf_dn_eop[g]                   = dn_out_w.eop;
    end

    // ---------------- upward: arbitrate, select, register ----------------
    cb_word_t         lf_w [N_LEAF];
    logic [N_LEAF-1:0] start_req;
    logic             gnt_vld;
    logic [IDX_W-1:0] gnt_idx;
    cb_word_t         sel_w, up_out_w;
    logic             sel_vld, up_in_rdy, up_xfer;

    for (genvar g = 0; g < N_LEAF; g++) begin : g_up_unpack
        assign lf_w[g]      = make_word(lf_up_data[g*WORD_W +: WORD_W],
                                        lf_up_sop[g], lf_up_eop[g]);
        assign start_req[g] = lf_up_src_rdy[g] && lf_up_sop[g];
        assign lf_up_dst_rdy[g] = gnt_vld && (gnt_idx == IDX_W'(g)) && up_in_rdy;
    end

    cbsw_rr_arb #(.N_LEAF(N_LEAF)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .xfer      (up_xfer),
        .xfer_eop  (sel_w.eop),
        .gnt_vld   (gnt_vld),
        .gnt_idx   (gnt_idx)
    );

    assign sel_w   = lf_w[gnt_idx];
    assign sel_vld = gnt_vld && lf_up_src_rdy[gnt_idx];
    assign up_xfer = sel_vld && up_in_rdy;

    cbsw_stage u_up_stage (
        .clk      (clk),
        .rst      (rst),
        .in_word  (sel_w),
        .in_vld   (sel_vld),
        .in_rdy   (up_in_rdy),
        .out_word (up_out_w),
        .out_vld  (rt_up_src_rdy),
        .out_rdy  (rt_up_dst_rdy)
    );

    assign rt_up_data = up_out_w.data;
    assign rt_up_sop  = up_out_w.sop;
    assign rt_up_eop  = up_out_w.eop;

    // R8
    one_leaf_ready_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lf_up_dst_rdy));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!rt_up_src_rdy && (lf_dn_src_rdy == '0)));

endmodule

// File: tb/tb_cbsw_switch.sv
module tb_cbsw_switch;
    localparam int N  = 4;
    localparam int W  = 16;
    localparam int QD = 16384;

    logic clk = 1'b0, rst = 1'b1;
    always #10 clk = ~clk;

    logic [W-1:0]   rt_dn_data = '0;
    logic           rt_dn_sop = 0, rt_dn_eop = 0, rt_dn_src_rdy = 0, rt_dn_dst_rdy;
    logic [W-1:0]   rt_up_data;
    logic           rt_up_sop, rt_up_eop, rt_up_src_rdy;
    logic           rt_up_dst_rdy = 0;
    logic [N*W-1:0] lf_dn_data;
    logic [N-1:0]   lf_dn_sop, lf_dn_eop, lf_dn_src_rdy;
    logic [N-1:0]   lf_dn_dst_rdy = '0;
    logic [N*W-1:0] lf_up_data = '0;
    logic [N-1:0]   lf_up_sop = '0, lf_up_eop = '0, lf_up_src_rdy = '0, lf_up_dst_rdy;

    cbsw_switch #(.N_LEAF(N)) dut (.*);

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int rr_expect(input logic [N-1:0] req, input int last);
        for (int k = 1; k <= N; k++) begin
            if (req[(last + k) % N]) return (last + k) % N;
        end
        return -1;
    endfunction

    // scoreboards
    logic [W+1:0] dn_exp [QD];
    logic [W+1:0] up_exp [QD];
    int dn_wr = 0, up_wr = 0, up_rd = 0;
    int dn_rd [N];
    int owner = -1, last_win = N - 1;
    bit xfl [N+1];
    bit mon_on = 0;

    initial begin
        for (int p = 0; p < N; p++) dn_rd[p] = 0;
        for (int s = 0; s <= N; s++) xfl[s] = 0;
    end

    always @(negedge clk) begin
        if (mon_on) begin
            logic [N-1:0] req;
            for (int s = 0; s <= N; s++) xfl[s] = 0;
            // downward acceptance
            if (rt_dn_src_rdy && rt_dn_dst_rdy) begin
                dn_exp[dn_wr % QD] = {rt_dn_data, rt_dn_sop, rt_dn_eop};
                dn_wr++;
                xfl[N] = 1;
            end
            if (|lf_dn_src_rdy) begin
                // R3 all leaves take together
                chk((&lf_dn_dst_rdy) && (&lf_dn_src_rdy), "R3", {lf_dn_src_rdy, lf_dn_dst_rdy}, 32'hFF);
            end
            for (int p = 0; p < N; p++) begin
                if (lf_dn_src_rdy[p] && lf_dn_dst_rdy[p]) begin
                    logic [W+1:0] got;
                    got = {lf_dn_data[p*W +: W], lf_dn_sop[p], lf_dn_eop[p]};
                    // R2 / R5 ordered copy of root words only
                    chk(dn_rd[p] < dn_wr && got == dn_exp[dn_rd[p] % QD], "R2", got, dn_exp[dn_rd[p] % QD]);
                    dn_rd[p]++;
                end
            end
            // R8
            chk($countones(lf_up_dst_rdy) <= 1, "R8", lf_up_dst_rdy, 1);
            req = lf_up_src_rdy & lf_up_sop;
            for (int p = 0; p < N; p++) begin
                if (lf_up_src_rdy[p] && lf_up_dst_rdy[p]) begin
                    xfl[p] = 1;
                    if (owner < 0) begin
                        int e;
                        e = rr_expect(req, last_win);
                        chk(lf_up_sop[p] && p == e, "R6", p, e);
                        last_win = p;
                        if (!lf_up_eop[p]) owner = p;
                    end else begin
                        chk(p == owner, "R7", p, owner);
                        if (lf_up_eop[p]) owner = -1;
                    end
                    up_exp[up_wr % QD] = {lf_up_data[p*W +: W], lf_up_sop[p], lf_up_eop[p]};
                    up_wr++;
                end
            end
            if (rt_up_src_rdy && rt_up_dst_rdy) begin
                logic [W+1:0] got;
                got = {rt_up_data, rt_up_sop, rt_up_eop};
                chk(up_rd < up_wr && got == up_exp[up_rd % QD], "R5", got, up_exp[up_rd % QD]);
                up_rd++;
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // random source state: index N is the root side
    bit           s_vld [N+1];
    int           s_rem [N+1];
    bit           s_first [N+1];
    logic [W+1:0] s_word [N+1];
    bit           no_new = 0;

    task automatic rand_cycle(input bit all_rdy);
        for (int s = 0; s <= N; s++) begin
            if (xfl[s]) s_vld[s] = 0;
            if (!s_vld[s]) begin
                if (s_rem[s] == 0 && !no_new && ($urandom % 4 == 0)) begin
                    s_rem[s] = 1 + ($urandom % 4);
                    s_first[s] = 1;
                end
                if (s_rem[s] > 0) begin
                    s_word[s] = {W'($urandom), s_first[s], (s_rem[s] == 1)};
                    s_rem[s]--;
                    s_first[s] = 0;
                    s_vld[s] = 1;
                end
            end
        end
        {rt_dn_data, rt_dn_sop, rt_dn_eop} = s_word[N];
        rt_dn_src_rdy = s_vld[N] && ($urandom % 8 != 0);
        for (int p = 0; p < N; p++) begin
            {lf_up_data[p*W +: W], lf_up_sop[p], lf_up_eop[p]} = s_word[p];
            lf_up_src_rdy[p] = s_vld[p] && ($urandom % 8 != 0);
            lf_dn_dst_rdy[p] = all_rdy || ($urandom % 8 != 0);
        end
        rt_up_dst_rdy = all_rdy || ($urandom % 4 != 0);
        step();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int s = 0; s <= N; s++) begin
            s_vld[s] = 0; s_rem[s] = 0; s_first[s] = 0; s_word[s] = '0;
        end
        // R1 during reset
        repeat (3) step();
        @(negedge clk);
        chk(!rt_up_src_rdy && lf_dn_src_rdy == '0, "R1", {rt_up_src_rdy, lf_dn_src_rdy}, 0);
        step();
        rst = 1'b0;
        mon_on = 1;
        step();
        @(negedge clk);
        chk(!rt_up_src_rdy && lf_dn_src_rdy == '0, "R1", {rt_up_src_rdy, lf_dn_src_rdy}, 0);

        // R10 downward latency, all leaves ready
        step();
        lf_dn_dst_rdy = '1;
        rt_dn_data = 16'h3C5A; rt_dn_sop = 1; rt_dn_eop = 1; rt_dn_src_rdy = 1;
        @(negedge clk);
        chk(lf_dn_src_rdy == '0, "R10", lf_dn_src_rdy, 0);
        step();
        rt_dn_src_rdy = 0;
        @(negedge clk);
        chk(lf_dn_src_rdy == '1 && lf_dn_data[W-1:0] == 16'h3C5A, "R10", {lf_dn_src_rdy, lf_dn_data[W-1:0]}, {4'hF, 16'h3C5A});

        // R3 partial downward backpressure holds the word back
        step();
        lf_dn_dst_rdy = 4'b1011;
        rt_dn_data = 16'h1111; rt_dn_src_rdy = 1;
        step();
        rt_dn_src_rdy = 0;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk(lf_dn_src_rdy == '0, "R3", lf_dn_src_rdy, 0);
            step();
        end
        lf_dn_dst_rdy = '1;
        @(negedge clk);
        chk(lf_dn_src_rdy == '1 && lf_dn_data[3*W +: W] == 16'h1111, "R3", lf_dn_src_rdy, 4'hF);
        step();

        // R4 upward stall
        rt_up_dst_rdy = 0;
        lf_up_data[2*W +: W] = 16'hA5C3; lf_up_sop[2] = 1; lf_up_eop[2] = 1; lf_up_src_rdy[2] = 1;
        @(negedge clk);
        chk(lf_up_dst_rdy == 4'b0100, "R4", lf_up_dst_rdy, 4'b0100);
        step();
        lf_up_src_rdy = '0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(rt_up_src_rdy && rt_up_data == 16'hA5C3, "R4", {rt_up_src_rdy, rt_up_data}, {1'b1, 16'hA5C3});
            if (i == 0) begin
                lf_up_data[1*W +: W] = 16'h0B0B; lf_up_sop[1] = 1; lf_up_eop[1] = 1;
                lf_up_data[0*W +: W] = 16'h0A0A; lf_up_sop[0] = 1; lf_up_eop[0] = 1;
            end
            step();
            lf_up_src_rdy[1:0] = 2'b11;
            @(negedge clk);
            chk(lf_up_dst_rdy == '0, "R4", lf_up_dst_rdy, 0);
            step();
        end
        // R9 back-to-back single-word packets from leaves 0 and 1
        rt_up_dst_rdy = 1;
        @(negedge clk);
        chk($countones(lf_up_dst_rdy[1:0]) == 1, "R9", lf_up_dst_rdy, 1);
        begin
            logic [N-1:0] first_rdy;
            first_rdy = lf_up_dst_rdy;
            step();
            lf_up_src_rdy = lf_up_src_rdy & ~first_rdy;
            @(negedge clk);
            chk(lf_up_dst_rdy == lf_up_src_rdy && lf_up_src_rdy != '0, "R9", lf_up_dst_rdy, lf_up_src_rdy);
            step();
        end
        lf_up_src_rdy = '0;
        lf_up_sop = '0; lf_up_eop = '0;
        repeat (4) step();

        // random traffic
        for (int c = 0; c < 3000; c++) rand_cycle(0);
        no_new = 1;
        for (int c = 0; c < 300; c++) rand_cycle(1);
        rt_dn_src_rdy = 0; lf_up_src_rdy = '0;
        repeat (4) step();
        @(negedge clk);
        for (int p = 0; p < N; p++) chk(dn_rd[p] == dn_wr, "R2", dn_rd[p], dn_wr);
        chk(up_rd == up_wr, "R5", up_rd, up_wr);
        chk(dn_wr > 100 && up_wr > 100, "R6", dn_wr, up_wr);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule